// File: doc/BRIEF.md
# Parallel Sample Read Port

This block hands 16-bit conversion results from an internal sample source to a host over a parallel bus that is driven only during a read. A new sample comes in as a one-cycle update strobe with its data word. The block captures that word in an output register and drops an active-low ready line to show that a fresh word is waiting. The host reads by holding chip select and the read strobe low. Both are level inputs that are sampled on the rising edge of the master clock. The bus is driven in the cycle after an edge that sees both low, and it floats otherwise.

A read counts as complete when an edge samples the read strobe high, provided the edge before it sampled the strobe low with chip select low. Completion raises the ready line again. If the word is never read, the block still marks the coming update. An internal counter is restarted by every update strobe and runs with a fixed update period. Two cycles before the expected next update, the ready line goes high. It then falls again when that update loads. The ready line stays high after reset until the first word arrives.

The control is a four-state machine:
- `ST_EMPTY`: no word since reset.
- `ST_FRESH`: an unread word is waiting, and ready is low.
- `ST_TAKEN`: the word has been read.
- `ST_GAP`: the word was not read and the pre-update pulse is running.

The transitions are:
- `load`: any state goes to `ST_FRESH` on an update strobe. This has the highest priority.
- `read_done`: `ST_FRESH` or `ST_GAP` goes to `ST_TAKEN` when a read completes.
- `near_update`: `ST_FRESH` goes to `ST_GAP` when the counter reaches the period minus three.

Top module: `pbus_read_port`

## Requirements
- R1: After reset the ready line `rdy_n` is 1, `db_oe` is 0 and `db` is high impedance, and this holds until the first update strobe.
- R2: When an edge samples `cs_n`=0 and `rd_n`=0, `db_oe` is 1 in the following cycle and `db` carries the output register.
- R3: When an edge samples `rd_n`=1 or `cs_n`=1, `db_oe` is 0 in the following cycle and all bits of `db` are high impedance.
- R4: The output register changes only at an edge that samples `smp_stb`=1, and it then takes `smp_word`. Its reset value is 0.
- R5: An edge that samples `smp_stb`=1 makes `rdy_n` 0 in the following cycle.
- R6: A read completes at an edge that samples `rd_n`=1 when the previous edge sampled `rd_n`=0 with `cs_n`=0. Completion of the current word makes `rdy_n` 1 in the following cycle, and it stays 1 until the next update.
- R7: If the current word has not been read, `rdy_n` rises after the edge at which the period counter holds `UPD_PERIOD`-3. The counter is 0 after an update edge. For updates that are `UPD_PERIOD` cycles apart, this makes `rdy_n` high for exactly the two cycles before the next update.
- R8: An update strobe takes priority over a read completion at the same edge, so `rdy_n` is 0 afterwards. The strobe restarts the period counter at 0. Otherwise the counter wraps from `UPD_PERIOD`-1 to 0.
- R9: Toggling `rd_n` while `cs_n`=1 has no effect on `rdy_n` and leaves `db` floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, level sampled |
| rd_n | input | 1 | Active-low read strobe, level sampled |
| smp_stb | input | 1 | One-cycle update strobe from the sample source |
| smp_word | input | DATA_W | Sample word loaded when `smp_stb` is sampled high |
| db | output | DATA_W | Three-state data bus |
| db_oe | output | 1 | Per-cycle bus output enable |
| rdy_n | output | 1 | Active-low data-ready line |

## Verification
The bench builds the block with `UPD_PERIOD`=8 and `DATA_W`=16, so one update interval lasts only eight cycles. A sweep then covers every read start offset within the interval, three read lengths, and three read kinds: a qualified read, a read with chip select high, and no read at all. With this short period, three cases come up many times in a few hundred cycles: the two-cycle pulse for unread words, reads that finish inside the pulse, and a read that completes at the same edge as the update. The expected ready, enable and bus values come from a per-cycle reference computed from the requirements.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FRESH = 2'd1,
        ST_TAKEN = 2'd2,
        ST_GAP   = 2'd3
    } rdp_state_e;

endpackage

// File: rtl/rdp_period_cnt.sv
module rdp_period_cnt #(
    parameter int PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic near_o
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(PERIOD - 1);
    localparam logic [CW-1:0] NEAR_V = CW'(PERIOD - 3);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST_V) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign near_o = (cnt_q == NEAR_V);

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0)); // R8
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt_q == LAST_V) |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/rdp_read_track.sv
module rdp_read_track (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    output logic oe_o,
    output logic done_o
);
    logic armed_q;
    logic oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            armed_q <= !cs_n && !rd_n;
            oe_q    <= !cs_n && !rd_n;
        end
    end

    assign oe_o   = oe_q;
    assign done_o = armed_q && rd_n;

    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |=> !oe_o); // R3
    AST_DONE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |=> !done_o || rd_n); // R6

endmodule

// File: rtl/rdp_word_reg.sv
module rdp_word_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              oe,
    output logic [DATA_W-1:0] q_o,
    output logic [DATA_W-1:0] bus_o
);
    logic [DATA_W-1:0] q_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else if (load) begin
            q_q <= din;
        end
    end

    assign q_o = q_q;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign bus_o[b] = oe ? q_q[b] : 1'bz;
    end

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q_q)); // R4
    AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q_q == $past(din))); // R4

endmodule

// File: rtl/pbus_read_port.sv
module pbus_read_port
    import rdp_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int UPD_PERIOD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] smp_word,
    output logic [DATA_W-1:0] db,
    output logic              db_oe,
    output logic              rdy_n
);
    rdp_state_e        st_q;
    rdp_state_e        st_d;
    logic              near;
    logic              done;
    logic [DATA_W-1:0] word_q;

    rdp_period_cnt #(.PERIOD(UPD_PERIOD)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (smp_stb),
        .near_o  (near)
    );

    rdp_read_track u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .oe_o   (db_oe),
        .done_o (done)
    );

    rdp_word_reg #(.DATA_W(DATA_W)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (smp_stb),
        .din   (smp_word),
        .oe    (db_oe),
        .q_o   (word_q),
        .bus_o (db)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (smp_stb) st_d = ST_FRESH;
            ST_FRESH: begin
                if (smp_stb)   st_d = ST_FRESH;
                else if (done) st_d = ST_TAKEN;
                else if (near) st_d = ST_GAP;
            end
            ST_GAP: begin
                if (smp_stb)   st_d = ST_FRESH;
                else if (done) st_d = ST_TAKEN;
            end
            ST_TAKEN: if (smp_stb) st_d = ST_FRESH;
            default:  st_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_FRESH: rdy_n = 1'b0;
            ST_EMPTY,
            ST_TAKEN,
            ST_GAP:   rdy_n = 1'b1;
            default:  rdy_n = 1'b1;
        endcase
    end

    AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !rdy_n); // R5
    AST_READ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && done && !smp_stb) |=> rdy_n); // R6
    AST_GAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FRESH && near && !smp_stb) |=> rdy_n); // R7
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EMPTY) |-> (rdy_n && word_q == '0)); // R1

endmodule

// File: tb/pbus_read_port_tb.sv
module pbus_read_port_tb;
    localparam int DW = 16;
    localparam int P  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n, rd_n, smp_stb;
    logic [DW-1:0] smp_word;
    wire  [DW-1:0] db;
    logic          db_oe, rdy_n;

    int checks = 0;
    int fails  = 0;

    pbus_read_port #(.DATA_W(DW), .UPD_PERIOD(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
        .smp_stb(smp_stb), .smp_word(smp_word),
        .db(db), .db_oe(db_oe), .rdy_n(rdy_n)
    );

    always #4 clk = ~clk;

    // reference state
    logic [DW-1:0] m_word;
    logic          m_oe, m_armed, m_rdy_n;
    int            m_cnt;
    int            m_st; // 0 empty, 1 fresh, 2 taken, 3 gap

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                       input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string rq);
        chk({15'd0, rdy_n}, {15'd0, m_rdy_n}, {rq, " rdy_n"});
        chk({15'd0, db_oe}, {15'd0, m_oe}, {rq, " R2/R3 db_oe"});
        if (m_oe) chk(db, m_word, {rq, " R2 R4 bus word"});
        else      chk(db, {DW{1'bz}}, {rq, " R3 bus float"});
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; smp_stb = 1'b0; smp_word = '0;
        m_word = '0; m_oe = 1'b0; m_armed = 1'b0; m_cnt = 0; m_st = 0; m_rdy_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1 reset");
        rst_n = 1'b1;
        for (int c = 0; c < 600; c++) begin
            int p, off, len, kind, ph;
            logic inwin, done, near;
            p    = c / P;
            ph   = c % P;
            off  = p % P;
            len  = 1 + (p / P) % 3;
            kind = (p / (3 * P)) % 3;
            inwin = (p >= 1) && (ph >= off) && (ph < off + len);
            smp_stb  = (ph == 0) && (c >= P);
            smp_word = 16'hA5C3 ^ DW'(c * 16'h1357);
            rd_n = !(inwin && kind != 2);
            cs_n = !(inwin && kind == 0);
            @(posedge clk);
            // reference update from requirements
            done    = m_armed && rd_n;                 // R6
            near    = (m_cnt == P - 3);                // R7
            m_armed = !cs_n && !rd_n;
            m_oe    = !cs_n && !rd_n;                  // R2 R3
            if (smp_stb) begin                         // R4 R5 R8
                m_word = smp_word;
                m_st   = 1;
                m_cnt  = 0;
            end else begin
                m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
                if (m_st == 1 && done)      m_st = 2;
                else if (m_st == 1 && near) m_st = 3;
                else if (m_st == 3 && done) m_st = 2;
            end
            m_rdy_n = (m_st != 1);
            #1;
            if (c < P)            compare_all("R1 before first update");
            else if (kind == 1)   compare_all("R9 cs high");
            else if (kind == 2)   compare_all("R7 unread pulse");
            else if (off + len >= P) compare_all("R8 R6 edge overlap");
            else                  compare_all("R5 R6 read cycle");
            if (smp_stb) chk({15'd0, rdy_n}, 16'd0, "R5 ready falls");
            smp_stb = 1'b0;
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule